// File: doc/BRIEF.md
# Daisy-Chainable Converter Serial Output Path

This block is the digital back end of a successive-approximation converter's serial port. A finished conversion result arrives as a parallel word with an end-of-conversion strobe. The word is held in two stages. The first is a hold latch written at end of conversion. The second is a shift register loaded from the hold latch when chip select falls. A conversion that finishes while a frame is being read therefore never disturbs that frame. The shift register drives the serial data output MSB first, and it advances by one bit on each falling serial-clock edge.

For chain operation, the chain data input is sampled on every rising serial-clock edge and enters the shift register behind the local result. Several blocks can then be strung into one long shift path. Reset has two sources: an asynchronous power-on reset, and a software reset request. The software request is armed during a frame and takes effect when chip select rises to end that frame. Either source sets every register to all ones and returns the control state to idle. The first frame read after either reset is all ones.

All port-side signals (`cs_n`, `sclk`) are sampled by the system clock. Their edges act two clock cycles after the pin changes.

Top module: `adc_sdo_chain`

## Requirements
- R1: `sdo_oe` is 1 while a frame is open and 0 otherwise. A frame opens two clock cycles after `cs_n` goes low and closes two cycles after it goes high.
- R2: An `eoc` pulse copies `sar_result` into the hold latch. A later pulse before the next `cs_n` fall replaces the earlier value.
- R3: At the `cs_n` falling edge the shift register loads the hold latch. `sdo` shows bit 15 first, and each `sclk` falling edge inside a frame advances one bit toward bit 0.
- R4: With `chain_en`=0, every bit after the 16th is 1, whatever `chain_in` carries.
- R5: With `chain_en`=1, the value of `chain_in` at the k-th `sclk` rising edge of a frame (k from 1) appears on `sdo` as bit 16+k-1 of that frame.
- R6: After `rst_n` is released, `sdo_oe` is 0 and the first frame is all ones, even if an `eoc` pulse came first.
- R7: A `swrst_wr` pulse during an open frame causes a software reset at the `cs_n` rising edge that closes the frame. The next frame is then all ones. A `swrst_wr` pulse while no frame is open is ignored.
- R8: An `eoc` pulse or an armed software reset during a frame leaves that frame's bits unchanged. The new `eoc` value shows in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| eoc | input | 1 | End-of-conversion strobe, one clock wide |
| sar_result | input | 16 | Conversion result from the SAR register |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| chain_en | input | 1 | 1 selects chain mode |
| chain_in | input | 1 | Chain data input from the upstream device |
| swrst_wr | input | 1 | Software reset bit written in the current frame |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable; 0 stands for high impedance |

## Verification
Some properties are checked on every cycle:
- The enable tracks a settled chip select.
- `sdo` only moves on a serial-clock fall, a frame load or a software reset.
- The hold latch captures on every strobe.
- The bit shifted in at the tail is the sampled chain bit, or a one outside chain mode.
- A software reset fires only on a chip-select rise.
- A load right after reset yields all ones.

Other behaviour only the scenarios can show: the full bit order of a frame, chained bits arriving 16 positions late, an `eoc` arriving mid-frame that surfaces only in the next frame, and an armed software reset that spares the current frame but blanks the next one.

// File: rtl/adc_sdo_pkg.sv
package adc_sdo_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } frame_st_e;
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rise = sync_q.s1 & ~sync_q.s2;
    assign fall = ~sync_q.s1 & sync_q.s2;
endmodule

// File: rtl/adc_hold_latch.sv
module adc_hold_latch #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [RES_W-1:0] din,
    input  logic             clear,
    output logic [RES_W-1:0] hold_q
);
    logic [RES_W-1:0] hold_d, hold_r;

    always_comb begin
        hold_d = hold_r;
        if (clear) begin
            hold_d = '1;
        end else if (capture) begin
            hold_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_r <= '1;
        end else begin
            hold_r <= hold_d;
        end
    end

    assign hold_q = hold_r;
endmodule

// File: rtl/adc_out_shifter.sv
module adc_out_shifter #(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             force_ones,
    input  logic [RES_W-1:0] load_val,
    input  logic             shift,
    input  logic             cap,
    input  logic             cdi,
    input  logic             chain_en,
    output logic [RES_W-1:0] out_q,
    output logic             cdi_q
);
    typedef struct packed {
        logic [RES_W-1:0] sr;
        logic             cdi;
    } shf_t;

    shf_t shf_d, shf_q;
    logic tail_bit;

    assign tail_bit = chain_en ? shf_q.cdi : 1'b1;

    always_comb begin
        shf_d = shf_q;
        if (clear) begin
            shf_d.sr  = '1;
            shf_d.cdi = 1'b1;
        end else begin
            if (load) begin
                shf_d.sr = force_ones ? '1 : load_val;
            end else if (shift) begin
                shf_d.sr = {shf_q.sr[RES_W-2:0], tail_bit};
            end
            if (cap) begin
                shf_d.cdi = cdi;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '{sr: '1, cdi: 1'b1};
        end else begin
            shf_q <= shf_d;
        end
    end

    assign out_q = shf_q.sr;
    assign cdi_q = shf_q.cdi;
endmodule

// File: rtl/adc_sdo_chain.sv
module adc_sdo_chain
    import adc_sdo_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoc,
    input  logic [RES_W-1:0] sar_result,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             chain_en,
    input  logic             chain_in,
    input  logic             swrst_wr,
    output logic             sdo,
    output logic             sdo_oe
);
    typedef struct packed {
        frame_st_e st;
        logic      sw_pend;
        logic      fresh;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic cs_rise, cs_fall;
    logic sclk_rise, sclk_fall;
    logic sw_apply;
    logic in_frame;
    logic [RES_W-1:0] hold_q;
    logic [RES_W-1:0] out_q;
    logic cdi_q;

    adc_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cs_n),
        .rise (cs_rise),
        .fall (cs_fall)
    );

    adc_edge_det #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    assign in_frame = (ctl_q.st == ST_FRAME);
    assign sw_apply = cs_rise & ctl_q.sw_pend;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE:  if (cs_fall) ctl_d.st = ST_FRAME;
            ST_FRAME: if (cs_rise) ctl_d.st = ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
        if (cs_fall) begin
            ctl_d.fresh = 1'b0;
        end
        if (in_frame && swrst_wr) begin
            ctl_d.sw_pend = 1'b1;
        end
        if (sw_apply) begin
            ctl_d.st      = ST_IDLE;
            ctl_d.sw_pend = 1'b0;
            ctl_d.fresh   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, sw_pend: 1'b0, fresh: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    adc_hold_latch #(.RES_W(RES_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(eoc),
        .din    (sar_result),
        .clear  (sw_apply),
        .hold_q (hold_q)
    );

    adc_out_shifter #(.RES_W(RES_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sw_apply),
        .load      (cs_fall),
        .force_ones(ctl_q.fresh),
        .load_val  (hold_q),
        .shift     (sclk_fall & in_frame),
        .cap       (sclk_rise & in_frame),
        .cdi       (chain_in),
        .chain_en  (chain_en),
        .out_q     (out_q),
        .cdi_q     (cdi_q)
    );

    assign sdo    = out_q[RES_W-1];
    assign sdo_oe = in_frame;
endmodule

// File: rtl/adc_sdo_chain_chk.sv
module adc_sdo_chain_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             eoc,
    input logic [RES_W-1:0] sar_result,
    input logic             chain_en,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             cs_fall,
    input logic             cs_rise,
    input logic             sclk_fall,
    input logic             sw_apply,
    input logic             fresh,
    input logic [RES_W-1:0] hold_q,
    input logic [RES_W-1:0] out_q,
    input logic             cdi_q
);
    logic [2:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 3'd7) begin
            age <= age + 3'd1;
        end
    end

    // R1: enable follows a settled chip select
    a_r1_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd3 && !cs_n && !$past(cs_n) && !$past(cs_n, 2)) |-> sdo_oe);

    a_r1_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd3 && cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe);

    // R2: strobe captures the result into the hold latch
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && !sw_apply) |=> (hold_q == $past(sar_result)));

    // R3: output moves only on a shift, a load or a software reset
    a_r3_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall && !sw_apply) |=> $stable(sdo));

    // R5: tail bit is the sampled chain bit in chain mode, a one otherwise (R4)
    a_r5_tail_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && sclk_fall && !cs_fall && !sw_apply)
        |=> (out_q[0] == ($past(chain_en) ? $past(cdi_q) : 1'b1)));

    // R6: a load straight after reset gives all ones
    a_r6_fresh_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && fresh && !sw_apply) |=> (out_q == '1));

    // R7: software reset is applied only when chip select rises
    a_r7_apply_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sw_apply |-> cs_rise);
endmodule

bind adc_sdo_chain adc_sdo_chain_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .eoc       (eoc),
    .sar_result(sar_result),
    .chain_en  (chain_en),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .sw_apply  (sw_apply),
    .fresh     (ctl_q.fresh),
    .hold_q    (hold_q),
    .out_q     (out_q),
    .cdi_q     (cdi_q)
);

// File: tb/adc_sdo_chain_tb.sv
module adc_sdo_chain_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc = 1'b0;
    logic [15:0] sar_result = '0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        chain_en = 1'b0;
    logic        chain_in = 1'b0;
    logic        swrst_wr = 1'b0;
    logic        sdo;
    logic        sdo_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic expq[$];

    always #10 clk = ~clk;

    adc_sdo_chain u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoc       (eoc),
        .sar_result(sar_result),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .chain_en  (chain_en),
        .chain_in  (chain_in),
        .swrst_wr  (swrst_wr),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_eoc(input logic [15:0] v);
        @(negedge clk);
        sar_result = v;
        eoc = 1'b1;
        @(negedge clk);
        eoc = 1'b0;
    endtask

    // driver: pushes expected bits; monitor side pops and compares at each bit slot
    task automatic run_frame(input string req, input int nbits, input logic [15:0] w,
                             input logic [63:0] cpat, input logic chain_on,
                             input logic [15:0] mid_eoc, input bit do_eoc,
                             input bit do_swrst);
        chain_en = chain_on;
        for (int i = 0; i < nbits; i++) begin
            if (i < 16) expq.push_back(w[15-i]);
            else        expq.push_back(chain_on ? cpat[i-16] : 1'b1);
        end
        @(negedge clk);
        cs_n = 1'b0;
        settle();
        chk({req, " R1 oe open"}, sdo_oe, 1'b1);
        for (int i = 0; i < nbits; i++) begin
            logic e;
            e = expq.pop_front();
            chk(req, sdo, e);
            if (i == 5 && do_eoc) pulse_eoc(mid_eoc);
            if (i == 7 && do_swrst) begin
                swrst_wr = 1'b1;
                @(negedge clk);
                swrst_wr = 1'b0;
            end
            chain_in = cpat[i];
            sclk = 1'b1;
            settle();
            sclk = 1'b0;
            settle();
        end
        cs_n = 1'b1;
        settle();
        chk({req, " R1 oe closed"}, sdo_oe, 1'b0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 R6 oe after reset", sdo_oe, 1'b0);

        // R6: first frame after power-on reset is all ones even with an eoc before it
        pulse_eoc(16'h1234);
        run_frame("R6 por frame", 16, 16'hFFFF, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);

        // R2 R3 R4: latched result MSB first, ones after 16 bits in normal mode
        run_frame("R2 R3 prior eoc", 16, 16'h1234, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);
        pulse_eoc(16'hA5C3);
        run_frame("R3 R4 word+tail", 20, 16'hA5C3, 64'h0005_0000, 1'b0, 16'h0, 1'b0, 1'b0);

        // R2: later eoc replaces earlier; R8: mid-frame eoc does not disturb
        pulse_eoc(16'h0F0F);
        pulse_eoc(16'h3C96);
        run_frame("R2 R8 replace", 16, 16'h3C96, 64'h0, 1'b0, 16'h8001, 1'b1, 1'b0);
        run_frame("R8 next frame", 16, 16'h8001, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);

        // R5: chain mode, upstream bits follow local word
        pulse_eoc(16'h5A17);
        run_frame("R5 chain", 32, 16'h5A17, 64'h0000_0000_B2E4_6D19, 1'b1, 16'h0, 1'b0, 1'b0);
        pulse_eoc(16'h7FFE);
        run_frame("R5 chain alt", 24, 16'h7FFE, 64'h0000_0000_00AA_0055, 1'b1, 16'h0, 1'b0, 1'b0);

        // R7 R8: armed software reset spares the frame, then blanks the next
        pulse_eoc(16'hC0DE);
        run_frame("R7 R8 armed", 16, 16'hC0DE, 64'h0, 1'b0, 16'h0, 1'b0, 1'b1);
        run_frame("R7 after swrst", 16, 16'hFFFF, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);
        pulse_eoc(16'h2468);
        run_frame("R7 recovered", 16, 16'h2468, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);

        // R7: swrst while no frame open is ignored
        pulse_eoc(16'h1357);
        @(negedge clk);
        swrst_wr = 1'b1;
        @(negedge clk);
        swrst_wr = 1'b0;
        settle();
        run_frame("R7 ignored idle", 16, 16'h1357, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);

        // R6: power-on reset mid-operation
        pulse_eoc(16'h4321);
        @(negedge clk);
        rst_n = 1'b0;
        settle();
        rst_n = 1'b1;
        settle();
        chk("R6 oe after reset", sdo_oe, 1'b0);
        pulse_eoc(16'h0000);
        run_frame("R6 por again", 16, 16'hFFFF, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);
        run_frame("R6 then latch", 16, 16'h0000, 64'h0, 1'b0, 16'h0, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule